// File: doc/BRIEF.md
# Serial ADC Result Reader

This block is a synchronous serial master that reads one 12-bit conversion result from an external ADC with a serial data output. A start request raises a conversion-start output for a programmable number of system cycles. After a programmable wait, the block drives a serial clock that idles low. It samples the ADC data line on every rising edge, because the converter changes that line on falling edges. The result arrives most significant bit first.

Two framings are selectable. Byte framing sends two bursts of eight clocks with a programmable low gap between them. The first burst returns the upper eight result bits. The first four clocks of the second burst return the lower four bits. Word framing sends one run of sixteen clocks, and the first twelve samples form the result. In both framings every sample after the twelfth is dropped, because the converter has released its output by then. An integer divider sets the half-period of the serial clock in system cycles. This keeps the serial clock at or below the converter's limit, which is 8 MHz for the single-run framing.

When a frame ends, the result register loads and a valid strobe is raised for exactly one cycle. A busy output covers the whole transaction. Start requests made while busy are ignored. All settings are captured when a start request is accepted.

Top module: `adc_serial_reader`

## Requirements
- R1: During reset and whenever the block is idle, `sclk`, `cnv`, `busy` and `result_valid` are low.
- R2: A start request made while idle is accepted at the next clock edge. `busy` and `cnv` rise together, and `cnv` stays high for max(`cnv_len`,1) cycles.
- R3: The first rising edge of `sclk` comes `wait_len` + max(`half_div`,1) cycles after `cnv` falls. `sclk` never toggles while `cnv` is high.
- R4: Inside a burst, every high phase and every low phase of `sclk` lasts H = max(`half_div`,1) cycles. A `half_div` of 0 acts as 1.
- R5: Each transaction has exactly 16 rising edges of `sclk`. `sdo` is sampled on each rising edge, and the first sample is result bit 11.
- R6: Byte framing (`frame_mode` = 0) splits the 16 clocks into two bursts of 8. The low time between the 8th falling edge and the 9th rising edge is `gap_len` + H cycles. Result bits 11..4 come from the first burst and bits 3..0 from the first four clocks of the second burst.
- R7: Word framing (`frame_mode` = 1) runs all 16 clocks without a gap. The first 12 samples form the result, bit 11 first.
- R8: Samples 13 to 16 have no effect on `result`.
- R9: `result_valid` is high for exactly one cycle, in the first cycle after the 16th falling edge of `sclk`. `result` holds its value until the next valid strobe.
- R10: A start request made while `busy` is high is ignored. No second `cnv` pulse follows, and the running frame finishes unchanged.
- R11: `frame_mode`, `half_div`, `cnv_len`, `wait_len` and `gap_len` are captured when a start request is accepted. Changing them during a transaction has no effect on that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one transaction (taken only when idle) |
| frame_mode | input | 1 | 0: two 8-clock bursts, 1: one 16-clock run |
| half_div | input | DIV_W | Serial clock half-period in system cycles (0 acts as 1) |
| cnv_len | input | CNV_W | Conversion-start pulse length in cycles (0 acts as 1) |
| wait_len | input | WAIT_W | Cycles between the end of the pulse and the first clock phase |
| gap_len | input | GAP_W | Extra low cycles between the two bursts in byte framing |
| sdo | input | 1 | Serial data from the ADC |
| sclk | output | 1 | Serial clock to the ADC, idle low |
| cnv | output | 1 | Conversion-start pulse to the ADC |
| busy | output | 1 | High from acceptance until the valid strobe |
| result | output | 12 | Last assembled conversion result |
| result_valid | output | 1 | One-cycle strobe when `result` is updated |

## Verification
The bench builds the block with DIV_W = 4, CNV_W = 3, WAIT_W = 3 and GAP_W = 4. With these widths, the largest field values (half-period 15, gap 15, pulse and wait 7) can be reached while each frame stays within a few hundred cycles. The zero settings for `half_div` and `cnv_len` are also exercised. These sizes put both saturating ends of each timing field in reach, so every low-time and high-time rule is measured against its exact expected cycle count. The ADC model drives the complement of the top result nibble in the four trailing slots. Any sample taken past the twelfth therefore corrupts the result that is checked.

// File: rtl/adcr_pkg.sv
package adcr_pkg;

  localparam int RES_BITS   = 12;
  localparam int FRAME_CLKS = 16;
  localparam int BURST_CLKS = 8;
  localparam int FCNT_W     = $clog2(FRAME_CLKS + 1);

  localparam logic [FCNT_W-1:0] RES_CNT   = FCNT_W'(RES_BITS);
  localparam logic [FCNT_W-1:0] FRAME_CNT = FCNT_W'(FRAME_CLKS);
  localparam logic [FCNT_W-1:0] BURST_CNT = FCNT_W'(BURST_CLKS);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CONV,
    PH_WAIT,
    PH_LOW,
    PH_HIGH,
    PH_GAP,
    PH_DONE
  } phase_e;

  typedef enum logic {
    FRM_BYTES = 1'b0,
    FRM_WORD  = 1'b1
  } frame_e;

  // A sample belongs to the result only while fewer than RES_BITS have been taken.
  function automatic logic keep_sample(input logic [FCNT_W-1:0] taken);
    return taken < RES_CNT;
  endfunction

  // Byte framing pauses after the first burst completes.
  function automatic logic burst_break(input frame_e mode,
                                       input logic [FCNT_W-1:0] falls);
    return (mode == FRM_BYTES) && (falls == BURST_CNT);
  endfunction

  function automatic logic frame_end(input logic [FCNT_W-1:0] falls);
    return falls == FRAME_CNT;
  endfunction

endpackage

// File: rtl/adcr_timer.sv
module adcr_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] elapsed
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elapsed <= '0;
    end else if (restart) begin
      elapsed <= '0;
    end else if (elapsed != '1) begin
      elapsed <= elapsed + 1'b1;
    end
  end

endmodule

// File: rtl/adcr_seq.sv
module adcr_seq
  import adcr_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int CNV_W  = 8,
  parameter int WAIT_W = 8,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              frame_mode,
  input  logic [DIV_W-1:0]  half_div,
  input  logic [CNV_W-1:0]  cnv_len,
  input  logic [WAIT_W-1:0] wait_len,
  input  logic [GAP_W-1:0]  gap_len,
  output logic              take,
  output logic              rise,
  output logic              fall,
  output logic              finish,
  output logic [FCNT_W-1:0] falls,
  output logic              sclk_q,
  output logic              cnv_q,
  output logic              busy_q,
  output logic              valid_q
);

  localparam int MAX_A = (DIV_W > CNV_W) ? DIV_W : CNV_W;
  localparam int MAX_B = (WAIT_W > GAP_W) ? WAIT_W : GAP_W;
  localparam int TMR_W = (MAX_A > MAX_B) ? MAX_A : MAX_B;

  function automatic logic [TMR_W-1:0] at_least_one(input logic [TMR_W-1:0] v);
    return (v == '0) ? TMR_W'(1) : v;
  endfunction

  phase_e             phase, phase_nx;
  frame_e             c_mode;
  logic [TMR_W-1:0]   c_div, c_cnv, c_wait, c_gap;
  logic [TMR_W-1:0]   elapsed, limit;
  logic [FCNT_W-1:0]  falls_inc;
  logic               last, restart;

  assign falls_inc = falls + 1'b1;
  assign take      = (phase == PH_IDLE) && start;
  assign restart   = (phase_nx != phase);
  assign last      = (elapsed == limit - 1'b1);

  adcr_timer #(.W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .elapsed (elapsed)
  );

  always_comb begin
    case (phase)
      PH_CONV:         limit = c_cnv;
      PH_WAIT:         limit = c_wait;
      PH_GAP:          limit = c_gap;
      PH_LOW, PH_HIGH: limit = c_div;
      default:         limit = TMR_W'(1);
    endcase
  end

  always_comb begin
    phase_nx = phase;
    rise     = 1'b0;
    fall     = 1'b0;
    case (phase)
      PH_IDLE: if (start) phase_nx = PH_CONV;
      PH_CONV: if (last) phase_nx = (c_wait == '0) ? PH_LOW : PH_WAIT;
      PH_WAIT: if (last) phase_nx = PH_LOW;
      PH_LOW: begin
        if (last) begin
          phase_nx = PH_HIGH;
          rise     = 1'b1;
        end
      end
      PH_HIGH: begin
        if (last) begin
          fall = 1'b1;
          if (frame_end(falls_inc))
            phase_nx = PH_DONE;
          else if (burst_break(c_mode, falls_inc) && (c_gap != '0))
            phase_nx = PH_GAP;
          else
            phase_nx = PH_LOW;
        end
      end
      PH_GAP:  if (last) phase_nx = PH_LOW;
      PH_DONE: phase_nx = PH_IDLE;
      default: phase_nx = PH_IDLE;
    endcase
  end

  assign finish = (phase_nx == PH_DONE) && (phase != PH_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      falls   <= '0;
      c_mode  <= FRM_BYTES;
      c_div   <= TMR_W'(1);
      c_cnv   <= TMR_W'(1);
      c_wait  <= '0;
      c_gap   <= '0;
      sclk_q  <= 1'b0;
      cnv_q   <= 1'b0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      phase   <= phase_nx;
      sclk_q  <= (phase_nx == PH_HIGH);
      cnv_q   <= (phase_nx == PH_CONV);
      busy_q  <= (phase_nx != PH_IDLE);
      valid_q <= (phase_nx == PH_DONE);
      if (take) begin
        falls  <= '0;
        c_mode <= frame_e'(frame_mode);
        c_div  <= at_least_one(TMR_W'(half_div));
        c_cnv  <= at_least_one(TMR_W'(cnv_len));
        c_wait <= TMR_W'(wait_len);
        c_gap  <= TMR_W'(gap_len);
      end else if (fall) begin
        falls <= falls_inc;
      end
    end
  end

endmodule

// File: rtl/adcr_capture.sv
module adcr_capture
  import adcr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                sample,
  input  logic [FCNT_W-1:0]   taken,
  input  logic                sdo,
  input  logic                load,
  output logic [RES_BITS-1:0] result
);

  logic [RES_BITS-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '0;
      result <= '0;
    end else begin
      if (clear)
        shreg <= '0;
      else if (sample && keep_sample(taken))
        shreg <= {shreg[RES_BITS-2:0], sdo};
      if (load)
        result <= shreg;
    end
  end

endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
  import adcr_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int CNV_W  = 8,
  parameter int WAIT_W = 8,
  parameter int GAP_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                frame_mode,
  input  logic [DIV_W-1:0]    half_div,
  input  logic [CNV_W-1:0]    cnv_len,
  input  logic [WAIT_W-1:0]   wait_len,
  input  logic [GAP_W-1:0]    gap_len,
  input  logic                sdo,
  output logic                sclk,
  output logic                cnv,
  output logic                busy,
  output logic [RES_BITS-1:0] result,
  output logic                result_valid
);

  // Internal events, named for the checker.
  logic              ev_take;
  logic              ev_rise;
  logic              ev_fall;
  logic              ev_finish;
  logic [FCNT_W-1:0] fall_count;

  adcr_seq #(
    .DIV_W  (DIV_W),
    .CNV_W  (CNV_W),
    .WAIT_W (WAIT_W),
    .GAP_W  (GAP_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .frame_mode (frame_mode),
    .half_div   (half_div),
    .cnv_len    (cnv_len),
    .wait_len   (wait_len),
    .gap_len    (gap_len),
    .take       (ev_take),
    .rise       (ev_rise),
    .fall       (ev_fall),
    .finish     (ev_finish),
    .falls      (fall_count),
    .sclk_q     (sclk),
    .cnv_q      (cnv),
    .busy_q     (busy),
    .valid_q    (result_valid)
  );

  adcr_capture u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (ev_take),
    .sample (ev_rise),
    .taken  (fall_count),
    .sdo    (sdo),
    .load   (ev_finish),
    .result (result)
  );

endmodule

// File: rtl/adcr_checker.sv
module adcr_checker
  import adcr_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                sclk,
  input logic                cnv,
  input logic                busy,
  input logic                result_valid,
  input logic [RES_BITS-1:0] result,
  input logic                ev_rise,
  input logic                ev_fall,
  input logic [FCNT_W-1:0]   fall_count
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && !cnv && !result_valid));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && cnv));

  p_cnv_no_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnv |-> !sclk);

  p_rise_drives_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rise |=> $rose(sclk));

  p_fall_drives_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fall |=> $fell(sclk));

  p_rise_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rise |-> (fall_count < FRAME_CNT));

  p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  p_valid_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $fell(sclk));

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(result));

  p_busy_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !result_valid) |=> busy);

  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cnv) |=> !cnv);

endmodule

bind adc_serial_reader adcr_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .sclk         (sclk),
  .cnv          (cnv),
  .busy         (busy),
  .result_valid (result_valid),
  .result       (result),
  .ev_rise      (ev_rise),
  .ev_fall      (ev_fall),
  .fall_count   (fall_count)
);

// File: tb/sim_adc_serial_reader.sv
module sim_adc_serial_reader;

  localparam int DIV_W  = 4;
  localparam int CNV_W  = 3;
  localparam int WAIT_W = 3;
  localparam int GAP_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic              frame_mode;
  logic [DIV_W-1:0]  half_div;
  logic [CNV_W-1:0]  cnv_len;
  logic [WAIT_W-1:0] wait_len;
  logic [GAP_W-1:0]  gap_len;
  logic              sdo = 1'b0;
  logic              sclk, cnv, busy, result_valid;
  logic [11:0]       result;

  always #5 clk = ~clk;

  adc_serial_reader #(
    .DIV_W(DIV_W), .CNV_W(CNV_W), .WAIT_W(WAIT_W), .GAP_W(GAP_W)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_mode(frame_mode),
    .half_div(half_div), .cnv_len(cnv_len), .wait_len(wait_len),
    .gap_len(gap_len), .sdo(sdo), .sclk(sclk), .cnv(cnv), .busy(busy),
    .result(result), .result_valid(result_valid)
  );

  typedef struct {
    logic [11:0] data;
    logic        mode;
    int          h;
    int          c;
    int          w;
    int          g;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0, n_pushed = 0, n_cnv = 0, n_res = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int floor1(input int v);
    return (v > 0) ? v : 1;
  endfunction

  // ADC model and monitor, both acting away from the active edge.
  int   k = 0, low_run = 0, high_run = 0, cnv_run = 0, rise_cnt = 0;
  bit   p_sclk = 0, p_cnv = 0, p_valid = 0;
  logic [15:0] word;
  exp_t cur;

  always @(negedge clk) begin
    if (!rst_n) begin
      k = 0; low_run = 0; high_run = 0; cnv_run = 0; rise_cnt = 0;
      p_sclk = 0; p_cnv = 0; p_valid = 0;
    end else begin
      if (q.size() > 0) cur = q[0];
      else begin cur.data = '0; cur.mode = 0; cur.h = -1; cur.c = -1; cur.w = -1; cur.g = -1; end
      // trailing four slots carry the inverse of the top nibble
      word = {cur.data, ~cur.data[11:8]};

      if (cnv) begin
        k = 0;
        sdo = word[15];
      end else if (p_sclk && !sclk) begin
        k++;
        sdo = (k < 16) ? word[15-k] : 1'b1;
      end

      if (cnv && !p_cnv) begin
        n_cnv++;
        cnv_run = 0;
      end
      if (!cnv && p_cnv) begin
        chk(cnv_run == cur.c, "R2 cnv pulse width", cnv_run, cur.c);
        low_run = 0;
      end
      if (cnv) begin
        chk(!sclk, "R3 no clock during cnv", sclk, 0);
        cnv_run++;
      end

      if (sclk && !p_sclk) begin
        if (rise_cnt == 0)
          chk(low_run == cur.w + cur.h, "R3 wait before first rise", low_run, cur.w + cur.h);
        else if (cur.mode == 1'b0 && rise_cnt == 8)
          chk(low_run == cur.g + cur.h, "R6 byte gap low time", low_run, cur.g + cur.h);
        else
          chk(low_run == cur.h, "R4 low phase", low_run, cur.h);
        rise_cnt++;
        low_run = 0;
      end
      if (!sclk && p_sclk) begin
        chk(high_run == cur.h, "R4 high phase", high_run, cur.h);
        high_run = 0;
      end

      if (sclk) high_run++;
      else if (busy && !cnv && !result_valid) low_run++;

      if (result_valid) begin
        chk(!p_valid, "R9 valid single cycle", p_valid, 0);
        chk(p_sclk && !sclk, "R9 valid after last fall", p_sclk, 1);
        chk(rise_cnt == 16, "R5 rising edge count", rise_cnt, 16);
        if (q.size() > 0) begin
          void'(q.pop_front());
          if (cur.mode)
            chk(result == cur.data, "R7 R8 word result", result, cur.data);
          else
            chk(result == cur.data, "R6 R8 byte result", result, cur.data);
        end else begin
          chk(0, "R10 unexpected result", 1, 0);
        end
        n_res++;
        rise_cnt = 0;
        low_run = 0;
      end
      p_sclk = sclk; p_cnv = cnv; p_valid = result_valid;
    end
  end

  // Driver: pushes the expectation, pulses start, optionally disturbs the run.
  task automatic run(input logic [11:0] data, input logic mode, input int div,
                     input int c, input int w, input int g, input bit disturb);
    exp_t e;
    logic [11:0] held;
    @(negedge clk);
    held       = result;
    frame_mode = mode;
    half_div   = DIV_W'(div);
    cnv_len    = CNV_W'(c);
    wait_len   = WAIT_W'(w);
    gap_len    = GAP_W'(g);
    e.data = data; e.mode = mode; e.h = floor1(div); e.c = floor1(c); e.w = w; e.g = g;
    q.push_back(e);
    n_pushed++;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && cnv, "R2 accepted with busy and cnv", {busy, cnv}, 3);
    chk(result == held, "R9 result held until strobe", result, held);
    if (disturb) begin
      repeat (12) @(negedge clk);
      start      = 1'b1;
      frame_mode = ~mode;
      half_div   = DIV_W'(div + 3);
      gap_len    = '0;
      wait_len   = '0;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(!busy && n_cnv == n_pushed, "R10 no extra transaction", n_cnv, n_pushed);
    chk(q.size() == 0, "R9 result delivered", q.size(), 0);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; frame_mode = 1'b0;
    half_div = '0; cnv_len = '0; wait_len = '0; gap_len = '0;
    repeat (4) @(negedge clk);
    chk({sclk, cnv, busy, result_valid} == 4'b0, "R1 outputs during reset",
        {sclk, cnv, busy, result_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({sclk, cnv, busy, result_valid} == 4'b0, "R1 outputs when idle",
        {sclk, cnv, busy, result_valid}, 0);
    chk(result == 12'h000, "R1 result after reset", result, 0);

    run(12'hA5C, 1'b0, 1,  1, 0, 0,  1'b0);
    run(12'h3F1, 1'b0, 3,  4, 2, 5,  1'b0);
    run(12'hFFF, 1'b1, 0,  0, 7, 0,  1'b0);
    run(12'h000, 1'b1, 15, 7, 1, 0,  1'b0);
    run(12'h801, 1'b0, 2,  3, 3, 15, 1'b1);   // R10 R11 disturbed run
    run(12'h5B6, 1'b1, 4,  2, 0, 9,  1'b1);   // R11 gap ignored in word framing
    run(12'h0F0, 1'b0, 1,  1, 0, 1,  1'b0);

    chk(n_res == n_pushed, "R9 result count", n_res, n_pushed);
    summary();
    $finish;
  end

endmodule